// File: doc/BRIEF.md
# Flash Bus Mode Decoder

This block is the bus front end of a byte-wide parallel flash model. It samples the active-low chip enable, output enable and write enable strobes, the address, the incoming data byte and three status flags. The flags are: the program supply is present, the identifier high voltage is on the upper address pin, and the supply is below the lockout threshold. From these it classifies each bus cycle as standby, output disable, array read, identifier read or write. It drives the data bus through a separate registered drive-enable.

A one-bit command state selects between array reads and identifier reads. A write cycle can update it only while the program supply is present and lockout is clear. Whenever the supply is absent or lockout is asserted, the state falls back to array read. The array is a small register file loaded with a fixed pattern at reset. No command in this block changes it.

All bus pins are plain levels. The block has no handshake. Every bus pattern held across one clock edge shows its effect on `dq_out`/`dq_oe` two edges later: one input sampling stage, then one output register.

Top module: `flash_busfront`

## Requirements
- R1: A read (ce_n=0, oe_n=0, we_n=1, id_volt=0, array-read state) drives dq_oe=1 and dq_out = (37*a + 17) mod 256 for address a, two clock edges after the pattern is sampled.
- R2: With ce_n=0 and oe_n=1, or with oe_n and we_n both low, dq_oe is 0 and dq_out is 0x00.
- R3: With ce_n=1 the block is in standby: dq_oe is 0 and dq_out is 0x00 whatever oe_n and we_n are.
- R4: A read with id_volt=1 returns 0x89 when addr[0]=0 and 0xB4 when addr[0]=1. The other address bits, the supply flag and the command state have no effect.
- R5: A write cycle is ce_n=0, we_n=0, oe_n=1. It completes when ce_n or we_n rises, and the command takes effect from that sample. A completed value of 0x90 selects the identifier-read state. Any other value, including 0x00, selects array read.
- R6: While vpp_hi=0 the command state is array read and writes are ignored. A read during vpp_hi=0 returns array data unless id_volt=1.
- R7: While lockout=1 the command state is array read and writes are ignored, even with vpp_hi=1.
- R8: In the identifier-read state, with vpp_hi=1 and lockout=0, a read returns 0x89 for addr[0]=0 and 0xB4 for addr[0]=1.
- R9: During and right after reset, dq_oe=0, dq_out=0x00, and the command state is array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address; bit 0 also picks the identifier code |
| dq_in | input | 8 | Data bus as seen by the device during writes |
| vpp_hi | input | 1 | Program supply present |
| id_volt | input | 1 | Identifier high voltage on the upper address pin |
| lockout | input | 1 | Supply below write-lockout threshold |
| dq_out | output | 8 | Data driven toward the bus |
| dq_oe | output | 1 | Drive enable for the data bus buffers |

## Verification
The decoder is exercised with sweeps of every array address in plain reads, with output-disable and standby patterns that toggle the idle strobes, and with pin-selected identifier reads that vary the upper address bits and the supply. These patterns separate the five bus modes from one another. Command sequences with 0x90 and other values, ended by either write enable or chip enable, show whether the write is latched and which edge completes it. The same sequences repeated with the supply low and with lockout high show that gating overrides a stored command. A long random phase, compared each clock with a behavioural model, mixes all of these and catches errors in ordering and latency.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  localparam logic [7:0] CMD_READ  = 8'h00;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] MFR_CODE  = 8'h89;
  localparam logic [7:0] DEV_CODE  = 8'hB4;

  typedef enum logic [2:0] {
    BUS_STANDBY,
    BUS_OUTDIS,
    BUS_READ,
    BUS_IDREAD,
    BUS_WRITE
  } bus_mode_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic vpp_hi;
    logic id_volt;
    logic lockout;
  } bus_ctl_t;

  localparam bus_ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                    vpp_hi: 1'b0, id_volt: 1'b0, lockout: 1'b0};

  function automatic logic [7:0] seed_byte(input int unsigned a);
    int unsigned v;
    v = (a * 37 + 17) % 256;
    return v[7:0];
  endfunction

  function automatic bus_mode_e decode_mode(input bus_ctl_t c);
    if (c.ce_n) return BUS_STANDBY;
    if (!c.we_n && c.oe_n) return BUS_WRITE;
    if (!c.oe_n && c.we_n) return c.id_volt ? BUS_IDREAD : BUS_READ;
    return BUS_OUTDIS;
  endfunction
endpackage

// File: rtl/fbf_in_stage.sv
module fbf_in_stage
  import fbf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_ctl_t      ctl_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output bus_ctl_t      ctl_s1,
  output logic [AW-1:0] addr_s1,
  output logic          wr_done,
  output logic [7:0]    wr_data
);
  bus_ctl_t   ctl_s2;
  logic [7:0] data_s1;
  logic [7:0] data_s2;
  logic       wr_s1;
  logic       wr_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_s1  <= CTL_IDLE;
      ctl_s2  <= CTL_IDLE;
      addr_s1 <= '0;
      data_s1 <= '0;
      data_s2 <= '0;
    end else begin
      ctl_s1  <= ctl_i;
      ctl_s2  <= ctl_s1;
      addr_s1 <= addr_i;
      data_s1 <= data_i;
      data_s2 <= data_s1;
    end
  end

  assign wr_s1   = (decode_mode(ctl_s1) == BUS_WRITE);
  assign wr_s2   = (decode_mode(ctl_s2) == BUS_WRITE);
  // the write ends when either strobe rises; the byte is the last one seen while active
  assign wr_done = wr_s2 && !wr_s1;
  assign wr_data = data_s2;
endmodule

// File: rtl/fbf_cmd_reg.sv
module fbf_cmd_reg
  import fbf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_done,
  input  logic [7:0] wr_data,
  input  logic       vpp_hi,
  input  logic       lockout,
  output logic       ident_mode
);
  logic gated;

  assign gated = !vpp_hi || lockout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ident_mode <= 1'b0;
    end else if (gated) begin
      ident_mode <= 1'b0;
    end else if (wr_done) begin
      ident_mode <= (wr_data == CMD_IDENT);
    end
  end
endmodule

// File: rtl/fbf_out_path.sv
module fbf_out_path
  import fbf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_ctl_t      ctl,
  input  logic [AW-1:0] addr,
  input  logic          ident_mode,
  output logic [7:0]    dq_out,
  output logic          dq_oe
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];
  bus_mode_e  mode;
  logic       use_id;
  logic       rd;
  logic [7:0] rd_byte;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[gi] <= seed_byte(gi);
        else        mem[gi] <= mem[gi];
      end
    end
  endgenerate

  always_comb begin
    mode    = decode_mode(ctl);
    rd      = (mode == BUS_READ) || (mode == BUS_IDREAD);
    use_id  = (mode == BUS_IDREAD) ||
              (ident_mode && ctl.vpp_hi && !ctl.lockout);
    rd_byte = use_id ? (addr[0] ? DEV_CODE : MFR_CODE) : mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= 8'h00;
      dq_oe  <= 1'b0;
    end else begin
      dq_out <= rd ? rd_byte : 8'h00;
      dq_oe  <= rd;
    end
  end
endmodule

// File: rtl/flash_busfront.sv
module flash_busfront
  import fbf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    dq_in,
  input  logic          vpp_hi,
  input  logic          id_volt,
  input  logic          lockout,
  output logic [7:0]    dq_out,
  output logic          dq_oe
);
  bus_ctl_t      ctl_in;
  bus_ctl_t      ctl_s1;
  logic [AW-1:0] addr_s1;
  logic          wr_done;
  logic [7:0]    wr_data;
  logic          ident_mode;

  assign ctl_in = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n,
                    vpp_hi: vpp_hi, id_volt: id_volt, lockout: lockout};

  fbf_in_stage #(.AW(AW)) u_in (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_in), .addr_i(addr), .data_i(dq_in),
    .ctl_s1(ctl_s1), .addr_s1(addr_s1), .wr_done(wr_done), .wr_data(wr_data)
  );

  fbf_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .wr_data(wr_data),
    .vpp_hi(ctl_s1.vpp_hi), .lockout(ctl_s1.lockout), .ident_mode(ident_mode)
  );

  fbf_out_path #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_s1), .addr(addr_s1),
    .ident_mode(ident_mode), .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/fbf_checker.sv
module fbf_checker #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic [AW-1:0] addr,
  input logic          id_volt,
  input logic [7:0]    dq_out,
  input logic          dq_oe
);
  logic [1:0] cyc;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end
  assign warm = (cyc >= 2'd2);

  // R2
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == 8'h00);

  // R1
  drive_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && dq_oe) |-> ($past(ce_n, 2) == 1'b0 && $past(oe_n, 2) == 1'b0 && $past(we_n, 2) == 1'b1));

  // R3
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(ce_n, 2)) |-> !dq_oe);

  // R4
  mfr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(!ce_n && !oe_n && we_n && id_volt && !addr[0], 2)) |-> dq_out == 8'h89);

  // R4
  dev_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(!ce_n && !oe_n && we_n && id_volt && addr[0], 2)) |-> dq_out == 8'hB4);
endmodule

bind flash_busfront fbf_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .addr(addr), .id_volt(id_volt), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/flash_busfront_bench.sv
module flash_busfront_bench;
  localparam int PER = 10;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dq_in = '0;
  logic          vpp_hi = 1'b0, id_volt = 1'b0, lockout = 1'b0;
  logic [7:0]    dq_out;
  logic          dq_oe;

  int total = 0;
  int bad = 0;

  always #(PER/2) clk = ~clk;

  flash_busfront #(.AW(AW)) u_flash_busfront (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .vpp_hi(vpp_hi), .id_volt(id_volt),
    .lockout(lockout), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  typedef struct {
    bit ce, oe, we, vpp, idv, lck;
    int a;
    int d;
  } snap_t;

  snap_t hist[$];
  bit    m_ident;
  snap_t lastneg;

  function automatic snap_t take();
    snap_t s;
    s.ce = ce_n; s.oe = oe_n; s.we = we_n;
    s.vpp = vpp_hi; s.idv = id_volt; s.lck = lockout;
    s.a = int'(addr); s.d = int'(dq_in);
    return s;
  endfunction

  function automatic snap_t idle();
    snap_t s;
    s.ce = 1; s.oe = 1; s.we = 1; s.vpp = 0; s.idv = 0; s.lck = 0; s.a = 0; s.d = 0;
    return s;
  endfunction

  function automatic bit is_wr(snap_t s);
    return !s.ce && !s.we && s.oe;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, stepped once per clock
  always @(negedge clk) begin
    if (!rst_n) begin
      hist = {};
      hist.push_back(idle());
      hist.push_back(idle());
      m_ident = 0;
      lastneg = take();
    end else begin
      snap_t q1, q2;
      int exp_dq;
      bit exp_oe;
      string tag;
      q1 = hist[1];
      q2 = hist[0];
      exp_oe = !q1.ce && !q1.oe && q1.we;
      if (!exp_oe) begin
        exp_dq = 0;
        tag = q1.ce ? "R3" : "R2";
      end else if (q1.idv) begin
        exp_dq = (q1.a % 2) ? 8'hB4 : 8'h89;
        tag = "R4";
      end else if (m_ident && q1.vpp && !q1.lck) begin
        exp_dq = (q1.a % 2) ? 8'hB4 : 8'h89;
        tag = "R8";
      end else begin
        exp_dq = (q1.a * 37 + 17) % 256;
        tag = "R1";
      end
      if (!q1.vpp || q1.lck) m_ident = 0;
      else if (is_wr(q2) && !is_wr(q1)) m_ident = (q2.d == 8'h90);
      void'(hist.pop_front());
      hist.push_back(lastneg);
      lastneg = take();
      check(tag, int'(dq_oe), int'(exp_oe));
      check(tag, int'(dq_out), exp_dq);
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic bus(bit c, bit o, bit w, int a, int d);
    ce_n = c; oe_n = o; we_n = w; addr = AW'(a); dq_in = 8'(d);
  endtask

  task automatic do_write(int d, bit end_by_ce);
    bus(0, 1, 0, 3, d);
    tick(1);
    if (end_by_ce) ce_n = 1; else we_n = 1;
    tick(1);
    bus(1, 1, 1, 0, 0);
  endtask

  task automatic read_expect(int a, int exp, string tag);
    bus(0, 0, 1, a, 0);
    tick(2);
    @(negedge clk);
    #1;
    check(tag, int'(dq_out), exp);
    tick(1);
    bus(1, 1, 1, 0, 0);
  endtask

  initial begin
    #(PER * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    // R9: reset state at the ports
    check("R9", int'(dq_oe), 0);
    check("R9", int'(dq_out), 0);
    rst_n = 1;
    tick(2);
    // R9: command starts as array read even with supply present
    vpp_hi = 1;
    read_expect(4, (4 * 37 + 17) % 256, "R9");
    vpp_hi = 0;
    // R1: sweep every address
    for (int a = 0; a < (1 << AW); a++) read_expect(a, (a * 37 + 17) % 256, "R1");
    // R2 and R3: idle strobes toggled
    bus(0, 1, 1, 5, 0); tick(3);
    bus(0, 0, 0, 5, 0); tick(3);
    bus(1, 0, 1, 5, 0); tick(3);
    bus(1, 0, 0, 5, 0); tick(3);
    // R4: pin-selected identifier, upper bits and supply varied
    id_volt = 1;
    read_expect(4'hE, 8'h89, "R4");
    vpp_hi = 1;
    read_expect(4'h7, 8'hB4, "R4");
    id_volt = 0;
    // R5: 0x90 latched on we_n release
    do_write(8'h90, 0);
    read_expect(2, 8'h89, "R5");
    read_expect(9, 8'hB4, "R8");
    // R5: other value returns to array read
    do_write(8'h55, 1);
    read_expect(9, (9 * 37 + 17) % 256, "R5");
    // R5: 0x90 latched on ce_n release
    do_write(8'h90, 1);
    read_expect(0, 8'h89, "R5");
    // R6: supply dropping reverts the state
    vpp_hi = 0; tick(1); vpp_hi = 1;
    read_expect(1, (1 * 37 + 17) % 256, "R6");
    // R6: write with supply low ignored
    vpp_hi = 0;
    do_write(8'h90, 0);
    vpp_hi = 1;
    read_expect(0, 17, "R6");
    // R7: write under lockout ignored
    lockout = 1;
    do_write(8'h90, 0);
    lockout = 0;
    read_expect(3, (3 * 37 + 17) % 256, "R7");
    // R7: lockout cancels an accepted command
    do_write(8'h90, 0);
    lockout = 1; tick(1); lockout = 0;
    read_expect(3, (3 * 37 + 17) % 256, "R7");
    // mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      ce_n = ($urandom % 5) == 0;
      oe_n = $urandom % 2;
      we_n = $urandom % 2;
      addr = AW'($urandom);
      dq_in = ($urandom % 2) ? 8'h90 : 8'($urandom);
      vpp_hi = ($urandom % 8) != 0;
      id_volt = ($urandom % 6) == 0;
      lockout = ($urandom % 12) == 0;
      tick(1);
    end
    bus(1, 1, 1, 0, 0);
    tick(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule